// File: doc/BRIEF.md
# ULPI Register Access Sequencer

This block sits on the link side of a ULPI connection and carries out PHY register reads and writes. A client hands over one request at a time through a valid/ready handshake: a direction bit, an 8-bit register address and, for writes, an 8-bit data byte. The block builds the transmit command byte and steps through the bus sequence. It drives the 8-bit data bus and the stop strobe, and it watches the direction and next-data strobes from the PHY. A single-cycle `done` pulse marks completion, and for reads `rdata` carries the byte returned by the PHY.

Addresses that fit the short 6-bit command field go out in one command byte. When the extended-addressing parameter is on, an address above 0x3F, or one that collides with the escape code 0x2F, is sent as the escape code followed by a full address byte. The PHY may take the bus at any point by raising the direction strobe. Every such takeover during an access aborts that attempt. The block then lets go of the bus, waits for the PHY to return it and starts the same access again, for as many attempts as it takes. The client sees exactly one completion.

A helper input, `hd_req`, turns on host-disconnect reporting. It writes the disconnect-enable mask through the set offset of both the rising-edge and the falling-edge interrupt-enable registers, and then pulses `hd_done`.

Top module: `ulpi_reg_access`

The sequencer states are IDLE, CMD, EXT, WDATA, STP, RTURN, RDATA, REND, ABORT and DONE. The transitions are:
- start: IDLE to CMD when work is offered and DIR is low.
- accept: one byte state to the next on NXT.
- stop: STP to DONE.
- turnaround: RTURN to RDATA on DIR with NXT low.
- capture: RDATA to REND.
- release: REND to DONE on DIR low.
- abort: any state that owns or expects the bus goes to ABORT on a takeover.
- retry: ABORT to CMD on DIR low.
- finish: DONE to IDLE.

The request arbiter states are A_IDLE, A_USER, A_HD_RISE and A_HD_FALL.

## Requirements
- R1: After reset `ulpi_data_out` is 8'h00, `ulpi_stp`, `done` and `hd_done` are 0, and `req_ready` is 1.
- R2: A write to an address below 8'h40 other than 8'h2F sends the command byte {2'b10, addr[5:0]} and then the data byte.
- R3: A read to such an address sends the command byte {2'b11, addr[5:0]}, and `rdata` holds the byte the PHY returned when `done` pulses.
- R4: With EXT_EN set, an address above 8'h3F or equal to 8'h2F sends the command low bits as 6'h2F, followed by the full 8-bit address as a second byte.
- R5: Each command, address and data byte stays unchanged on `ulpi_data_out` until a cycle in which NXT is high and DIR is low.
- R6: After the data byte of a write is accepted, `ulpi_stp` is high for exactly one cycle with the bus at 8'h00, the bus then stays at 8'h00, and `done` pulses in the following cycle.
- R7: After a read command is accepted, the block waits for DIR high with NXT low (turnaround). It captures `ulpi_data_in` in the next cycle while DIR stays high and NXT low, and it signals `done` only after DIR has fallen.
- R8: An access is aborted when DIR is high in a command, address, data or stop cycle, when DIR and NXT are both high in the turnaround or capture cycle, or when DIR is low in the capture cycle. From the cycle after DIR is seen high, the block drives 8'h00.
- R9: An aborted access restarts from its command byte once DIR is low, and repeats until it completes. Each accepted request yields exactly one `done`, with the data of the successful attempt.
- R10: No access starts while DIR is high.
- R11: A pulse on `hd_req` performs a write of HDISC_MASK (8'h01) to 8'h0E (interrupt-enable rising 8'h0D plus set offset 1), then a write of the same mask to 8'h11 (interrupt-enable falling 8'h10 plus set offset 1), then pulses `hd_done` once, never together with `done`.
- R12: `req_ready` is low while any access or helper sequence is in progress. When `hd_req` and `req_valid` arrive together, the helper sequence runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, the ULPI interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a register access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Block accepts a request this cycle |
| hd_req | input | 1 | Pulse: enable host-disconnect reporting |
| done | output | 1 | One-cycle pulse when a client access has completed |
| rdata | output | 8 | Data of the last completed read |
| hd_done | output | 1 | One-cycle pulse when the helper sequence has completed |
| ulpi_dir | input | 1 | PHY owns the bus when high |
| ulpi_nxt | input | 1 | PHY throttle / byte accept strobe |
| ulpi_data_in | input | 8 | Bus value driven by the PHY |
| ulpi_data_out | output | 8 | Bus value driven by the link |
| ulpi_data_oe | output | 1 | Link output enable for the bus |
| ulpi_stp | output | 1 | Stop strobe ending a write |

## Verification
The bench uses a behavioural PHY model that keeps its own register array. It takes the bus at each cycle of every access kind in turn: immediate and extended, read and write, from the command byte through the stop cycle and the read release. A design that missed an abort would either keep driving a command into a PHY-owned bus or latch the 8'hEE garbage as read data. A design that failed to retry would hang, and one that signalled completion per attempt would produce a second `done` that the scoreboard rejects. Throttled NXT checks that bytes are held rather than advanced. Address 8'h2F and addresses above 8'h3F expose a wrong escape decision as a write landing in the wrong PHY register. A simultaneous helper and client request shows whether the arbitration order is right.

// File: rtl/ulpi_reg_pkg.sv
package ulpi_reg_pkg;

    localparam int ULPI_W = 8;

    localparam logic [1:0] TXCMD_WR  = 2'b10;
    localparam logic [1:0] TXCMD_RD  = 2'b11;
    localparam logic [5:0] ESC_CODE  = 6'h2F;

    typedef struct packed {
        logic              write;
        logic [ULPI_W-1:0] addr;
        logic [ULPI_W-1:0] wdata;
    } reg_op_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_EXT,
        S_WDATA,
        S_STP,
        S_RTURN,
        S_RDATA,
        S_REND,
        S_ABORT,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        A_IDLE,
        A_USER,
        A_HD_RISE,
        A_HD_FALL
    } arb_state_e;

endpackage

// File: rtl/ulpi_txcmd_enc.sv
module ulpi_txcmd_enc
    import ulpi_reg_pkg::*;
#(
    parameter bit EXT_EN = 1'b1
) (
    input  reg_op_t           op,
    output logic [ULPI_W-1:0] cmd_byte,
    output logic [ULPI_W-1:0] ext_byte,
    output logic              use_ext
);

    localparam int SHORT_W = ULPI_W - 2;

    logic [SHORT_W-1:0] short_field;

    generate
        if (EXT_EN) begin : g_ext
            // escape when the address does not fit or collides with the escape code
            assign use_ext = (op.addr[ULPI_W-1:SHORT_W] != '0) ||
                             (op.addr[SHORT_W-1:0] == ESC_CODE);
        end else begin : g_imm
            assign use_ext = 1'b0;
        end
    endgenerate

    assign short_field = use_ext ? ESC_CODE : op.addr[SHORT_W-1:0];
    assign cmd_byte    = {(op.write ? TXCMD_WR : TXCMD_RD), short_field};
    assign ext_byte    = op.addr;

endmodule

// File: rtl/ulpi_op_arb.sv
module ulpi_op_arb
    import ulpi_reg_pkg::*;
#(
    parameter logic [ULPI_W-1:0] RISE_SET_ADDR = 8'h0E,
    parameter logic [ULPI_W-1:0] FALL_SET_ADDR = 8'h11,
    parameter logic [ULPI_W-1:0] HDISC_MASK    = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ULPI_W-1:0] req_addr,
    input  logic [ULPI_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              hd_req,
    input  logic              fsm_done,
    output logic              op_valid,
    output reg_op_t           op,
    output logic              user_done,
    output logic              helper_done
);

    arb_state_e state_q, state_d;
    reg_op_t    user_op_q;
    logic       hd_pend_q;
    logic       want_hd;

    assign want_hd   = hd_req || hd_pend_q;
    assign req_ready = (state_q == A_IDLE) && !want_hd;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= A_IDLE;
            hd_pend_q <= 1'b0;
            user_op_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == A_IDLE) begin
                hd_pend_q <= 1'b0;
            end else if (hd_req) begin
                hd_pend_q <= 1'b1;
            end
            if (req_ready && req_valid) begin
                user_op_q <= '{write: req_write, addr: req_addr, wdata: req_wdata};
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            A_IDLE: begin
                if (want_hd) begin
                    state_d = A_HD_RISE;
                end else if (req_valid) begin
                    state_d = A_USER;
                end
            end
            A_USER:    if (fsm_done) state_d = A_IDLE;
            A_HD_RISE: if (fsm_done) state_d = A_HD_FALL;
            A_HD_FALL: if (fsm_done) state_d = A_IDLE;
            default:   state_d = A_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        op_valid    = 1'b0;
        op          = user_op_q;
        user_done   = 1'b0;
        helper_done = 1'b0;
        unique case (state_q)
            A_IDLE: ;
            A_USER: begin
                op_valid  = 1'b1;
                user_done = fsm_done;
            end
            A_HD_RISE: begin
                op_valid = 1'b1;
                op       = '{write: 1'b1, addr: RISE_SET_ADDR, wdata: HDISC_MASK};
            end
            A_HD_FALL: begin
                op_valid    = 1'b1;
                op          = '{write: 1'b1, addr: FALL_SET_ADDR, wdata: HDISC_MASK};
                helper_done = fsm_done;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ulpi_seq_fsm.sv
module ulpi_seq_fsm
    import ulpi_reg_pkg::*;
#(
    parameter bit EXT_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  reg_op_t           op_in,
    input  logic              dir,
    input  logic              nxt,
    input  logic [ULPI_W-1:0] din,
    output logic [ULPI_W-1:0] dout,
    output logic              stp,
    output logic              fsm_done,
    output logic [ULPI_W-1:0] rdata
);

    seq_state_e        state_q, state_d;
    reg_op_t           cur_q;
    logic [ULPI_W-1:0] rdata_q;
    logic [ULPI_W-1:0] cmd_byte;
    logic [ULPI_W-1:0] ext_byte;
    logic              use_ext;
    logic              start;
    logic              capture;

    ulpi_txcmd_enc #(.EXT_EN(EXT_EN)) u_enc (
        .op       (cur_q),
        .cmd_byte (cmd_byte),
        .ext_byte (ext_byte),
        .use_ext  (use_ext)
    );

    assign start   = (state_q == S_IDLE) && op_valid && !dir;
    assign capture = (state_q == S_RDATA) && dir && !nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                cur_q <= op_in;
            end
            if (capture) begin
                rdata_q <= din;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (op_valid && !dir) state_d = S_CMD;
            S_CMD: begin
                if (dir) begin
                    state_d = S_ABORT;
                end else if (nxt) begin
                    if (use_ext)          state_d = S_EXT;
                    else if (cur_q.write) state_d = S_WDATA;
                    else                  state_d = S_RTURN;
                end
            end
            S_EXT: begin
                if (dir) begin
                    state_d = S_ABORT;
                end else if (nxt) begin
                    state_d = cur_q.write ? S_WDATA : S_RTURN;
                end
            end
            S_WDATA: begin
                if (dir)      state_d = S_ABORT;
                else if (nxt) state_d = S_STP;
            end
            S_STP:   state_d = dir ? S_ABORT : S_DONE;
            S_RTURN: begin
                if (dir && nxt) state_d = S_ABORT;
                else if (dir)   state_d = S_RDATA;
            end
            S_RDATA: state_d = (dir && !nxt) ? S_REND : S_ABORT;
            S_REND:  if (!dir) state_d = S_DONE;
            S_ABORT: if (!dir) state_d = S_CMD;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        dout     = '0;
        stp      = 1'b0;
        fsm_done = 1'b0;
        unique case (state_q)
            S_CMD:   dout     = cmd_byte;
            S_EXT:   dout     = ext_byte;
            S_WDATA: dout     = cur_q.wdata;
            S_STP:   stp      = 1'b1;
            S_DONE:  fsm_done = 1'b1;
            S_IDLE, S_RTURN, S_RDATA, S_REND, S_ABORT: ;
            default: ;
        endcase
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/ulpi_reg_access.sv
module ulpi_reg_access
    import ulpi_reg_pkg::*;
#(
    parameter bit                EXT_EN        = 1'b1,
    parameter logic [ULPI_W-1:0] IEN_RISE_ADDR = 8'h0D,
    parameter logic [ULPI_W-1:0] IEN_FALL_ADDR = 8'h10,
    parameter logic [ULPI_W-1:0] SET_OFS       = 8'h01,
    parameter logic [ULPI_W-1:0] HDISC_MASK    = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ULPI_W-1:0] req_addr,
    input  logic [ULPI_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic              hd_req,
    output logic              done,
    output logic [ULPI_W-1:0] rdata,
    output logic              hd_done,
    input  logic              ulpi_dir,
    input  logic              ulpi_nxt,
    input  logic [ULPI_W-1:0] ulpi_data_in,
    output logic [ULPI_W-1:0] ulpi_data_out,
    output logic              ulpi_data_oe,
    output logic              ulpi_stp
);

    localparam logic [ULPI_W-1:0] RISE_SET_ADDR = IEN_RISE_ADDR + SET_OFS;
    localparam logic [ULPI_W-1:0] FALL_SET_ADDR = IEN_FALL_ADDR + SET_OFS;

    logic    op_valid;
    reg_op_t op;
    logic    fsm_done;

    ulpi_op_arb #(
        .RISE_SET_ADDR (RISE_SET_ADDR),
        .FALL_SET_ADDR (FALL_SET_ADDR),
        .HDISC_MASK    (HDISC_MASK)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .hd_req      (hd_req),
        .fsm_done    (fsm_done),
        .op_valid    (op_valid),
        .op          (op),
        .user_done   (done),
        .helper_done (hd_done)
    );

    ulpi_seq_fsm #(.EXT_EN(EXT_EN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_in    (op),
        .dir      (ulpi_dir),
        .nxt      (ulpi_nxt),
        .din      (ulpi_data_in),
        .dout     (ulpi_data_out),
        .stp      (ulpi_stp),
        .fsm_done (fsm_done),
        .rdata    (rdata)
    );

    assign ulpi_data_oe = !ulpi_dir;

endmodule

// File: rtl/ulpi_reg_access_chk.sv
module ulpi_reg_access_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic       hd_done,
    input logic       ulpi_dir,
    input logic       ulpi_nxt,
    input logic [7:0] ulpi_data_out,
    input logic       ulpi_stp
);

    AST_STP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ulpi_stp |=> !ulpi_stp);                                              // R6

    AST_STP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ulpi_stp |-> ($past(ulpi_nxt) && !$past(ulpi_dir)));                  // R6

    AST_BUS_IDLE_AFTER_STP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ulpi_stp) |-> (ulpi_data_out == 8'h00));                        // R6

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ulpi_data_out) != 8'h00) && !$past(ulpi_nxt) && !$past(ulpi_dir))
        |-> (ulpi_data_out == $past(ulpi_data_out)));                         // R5

    AST_RELEASE_ON_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ulpi_dir) |-> (ulpi_data_out == 8'h00));                        // R8

    AST_NO_START_UNDER_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ulpi_data_out[7]) |-> !$past(ulpi_dir));                        // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                      // R9

    AST_DONE_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(ulpi_dir));                                           // R7

    AST_DONE_KINDS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && hd_done));                                                  // R11

endmodule

bind ulpi_reg_access ulpi_reg_access_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .done          (done),
    .hd_done       (hd_done),
    .ulpi_dir      (ulpi_dir),
    .ulpi_nxt      (ulpi_nxt),
    .ulpi_data_out (ulpi_data_out),
    .ulpi_stp      (ulpi_stp)
);

// File: tb/ulpi_reg_access_bench.sv
`timescale 1ns/1ps
module ulpi_reg_access_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [7:0] req_addr = '0, req_wdata = '0;
    logic       req_ready;
    logic       hd_req = 1'b0;
    logic       done, hd_done;
    logic [7:0] rdata;
    logic       dir = 1'b0, nxt = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       oe, stp;

    always #(CLK_PERIOD/2) clk = ~clk;

    ulpi_reg_access u_ulpi_reg_access (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_wdata (req_wdata), .req_ready (req_ready), .hd_req (hd_req),
        .done (done), .rdata (rdata), .hd_done (hd_done),
        .ulpi_dir (dir), .ulpi_nxt (nxt), .ulpi_data_in (din),
        .ulpi_data_out (dout), .ulpi_data_oe (oe), .ulpi_stp (stp)
    );

    int n_chk = 0, n_err = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- PHY model ----------------
    localparam int M_IDLE = 0, M_CMD = 1, M_EXT = 2, M_WDATA = 3, M_RTURN = 4, M_RDATA = 5;

    logic [7:0] phy_regs [256];
    int         ms = M_IDLE;
    bit         is_wr, is_ext;
    logic [7:0] addr_q, wd_q, prev_b;
    logic [7:0] last_cmd = '0;
    bit         last_ext = 0;
    int         stall_n = 0, stall_c = 0;
    int         hold = 0;
    bit         seen = 0;
    int         opcyc = 0;
    int         inj_at = -1;
    bit         inj_armed = 0;
    bit         pre_busy = 0;
    int         err_hold = 0, err_stp = 0, err_drive = 0;

    task automatic phy_take(output bit took);
        if (stall_c != 0 && dout != prev_b) err_hold++;
        prev_b = dout;
        if (stall_c < stall_n) begin
            stall_c++; nxt = 1'b0; took = 0;
        end else begin
            stall_c = 0; nxt = 1'b1; took = 1;
        end
    endtask

    always @(negedge clk) begin
        bit t;
        if (!rst_n) begin
            ms = M_IDLE; dir = 0; nxt = 0; din = 0; hold = 0; stall_c = 0;
        end else begin
            if (seen) opcyc++;
            if (!seen && dout[7:6] != 2'b00) begin seen = 1; opcyc = 0; end
            if (dir && dout != 8'h00) err_drive++;
            if (pre_busy) begin
                pre_busy = 0; hold = 6; dir = 1; nxt = 0; din = 0; ms = M_IDLE;
            end else if (hold != 0) begin
                hold--; nxt = 0;
                if (hold == 0) begin dir = 0; din = 0; end
            end else if (inj_armed && seen && opcyc == inj_at) begin
                inj_armed = 0; hold = 3; dir = 1; nxt = 1; din = 8'hEE;
                ms = M_IDLE; stall_c = 0;
            end else begin
                case (ms)
                    M_IDLE: begin
                        dir = 0; nxt = 0; din = 0;
                        if (stp) err_stp++;
                        if (dout[7:6] == 2'b10 || dout[7:6] == 2'b11) begin
                            phy_take(t);
                            if (t) begin
                                is_wr = (dout[7:6] == 2'b10);
                                is_ext = (dout[5:0] == 6'h2F);
                                addr_q = {2'b00, dout[5:0]};
                                last_cmd = dout; last_ext = is_ext;
                                ms = M_CMD;
                            end
                        end
                    end
                    M_CMD, M_EXT: begin
                        nxt = 0;
                        if (ms == M_CMD && is_ext) begin
                            phy_take(t);
                            if (t) begin addr_q = dout; ms = M_EXT; end
                        end else if (is_wr) begin
                            phy_take(t);
                            if (t) begin wd_q = dout; ms = M_WDATA; end
                        end else begin
                            dir = 1; ms = M_RTURN;
                        end
                    end
                    M_WDATA: begin
                        nxt = 0;
                        if (!stp || dout != 8'h00) err_stp++;
                        else phy_regs[addr_q] = wd_q;
                        ms = M_IDLE;
                    end
                    M_RTURN: begin
                        din = phy_regs[addr_q]; dir = 1; nxt = 0; ms = M_RDATA;
                    end
                    default: begin
                        dir = 0; din = 0; ms = M_IDLE;
                    end
                endcase
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit         wr;
        logic [7:0] a;
        logic [7:0] d;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0, done_cyc = 0, hd_cyc = 0, hd_cnt = 0;

    always @(posedge clk) cyc++;

    always @(negedge clk) begin
        if (rst_n) begin
            if (hd_done) begin hd_cnt++; hd_cyc = cyc; end
            if (done) begin
                done_cyc = cyc;
                if (exp_q.size() == 0) begin
                    check(0, "R9", "done without pending request", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (e.wr)
                        check(phy_regs[e.a] == e.d, e.req, "written PHY register", phy_regs[e.a], e.d);
                    else
                        check(rdata == e.d, e.req, "read data", rdata, e.d);
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic send_req(bit w, logic [7:0] a, logic [7:0] d);
        bit acc;
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        acc = 0;
        while (!acc) begin
            #1 acc = req_ready;
            @(negedge clk);
        end
        req_valid = 0;
    endtask

    task automatic run_op(bit w, logic [7:0] a, logic [7:0] d, int inj, string req);
        exp_t e;
        seen = 0;
        inj_at = inj;
        inj_armed = (inj >= 0);
        e.wr = w; e.a = a; e.d = w ? d : phy_regs[a]; e.req = req;
        exp_q.push_back(e);
        send_req(w, a, d);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic run_tests();
        for (int i = 0; i < 256; i++) phy_regs[i] = 8'(i ^ 8'h5A);
        repeat (4) @(negedge clk);
        // R1 reset state
        check(dout == 8'h00, "R1", "bus in reset", dout, 0);
        check(stp == 0, "R1", "stp in reset", stp, 0);
        check(done == 0 && hd_done == 0, "R1", "done flags in reset", done, 0);
        rst_n = 1;
        @(negedge clk);
        check(req_ready == 1, "R1", "ready after reset", req_ready, 1);

        // R2 immediate write, R3 immediate read
        run_op(1, 8'h05, 8'hA5, -1, "R2");
        check(last_cmd == 8'h85, "R2", "write command byte", last_cmd, 8'h85);
        run_op(0, 8'h05, 8'h00, -1, "R3");
        check(last_cmd == 8'hC5, "R3", "read command byte", last_cmd, 8'hC5);
        run_op(0, 8'h3E, 8'h00, -1, "R3");

        // R4 extended addressing
        run_op(1, 8'h2F, 8'h3C, -1, "R4");
        check(last_cmd == 8'hAF && last_ext, "R4", "escape write command", last_cmd, 8'hAF);
        run_op(1, 8'h80, 8'h77, -1, "R4");
        run_op(0, 8'h80, 8'h00, -1, "R4");
        check(last_cmd == 8'hEF && last_ext, "R4", "escape read command", last_cmd, 8'hEF);
        run_op(0, 8'hC3, 8'h00, -1, "R4");

        // R5 throttled NXT
        stall_n = 3;
        run_op(1, 8'h16, 8'h9B, -1, "R5");
        run_op(1, 8'h91, 8'h4D, -1, "R5");
        run_op(0, 8'h91, 8'h00, -1, "R5");
        stall_n = 0;

        // R8 R9 takeover at every phase
        for (int k = 0; k <= 4; k++) run_op(1, 8'h12, 8'(8'h40 + k), k, "R9");
        for (int k = 0; k <= 5; k++) run_op(1, 8'hA0, 8'(8'h60 + k), k, "R9");
        for (int k = 0; k <= 5; k++) run_op(0, 8'h12, 8'h00, k, "R8");
        for (int k = 0; k <= 6; k++) run_op(0, 8'hA0, 8'h00, k, "R8");

        // R10 bus already owned by PHY when request arrives
        pre_busy = 1;
        @(negedge clk);
        run_op(1, 8'h22, 8'h6E, -1, "R10");

        // R11 helper
        begin
            int h0;
            h0 = hd_cnt;
            hd_req = 1;
            @(negedge clk);
            hd_req = 0;
            #1 check(req_ready == 0, "R12", "ready while helper busy", req_ready, 0);
            while (hd_cnt == h0) @(negedge clk);
            repeat (6) @(negedge clk);
            check(hd_cnt == h0 + 1, "R11", "helper completions", hd_cnt - h0, 1);
            check(phy_regs[8'h0D + 8'h01] == 8'h01, "R11", "rising enable set register", phy_regs[8'h0E], 1);
            check(phy_regs[8'h10 + 8'h01] == 8'h01, "R11", "falling enable set register", phy_regs[8'h11], 1);
        end

        // R12 simultaneous helper and client request
        begin
            exp_t e;
            int h0;
            h0 = hd_cnt;
            phy_regs[8'h0E] = 8'h00; phy_regs[8'h11] = 8'h00;
            seen = 0; inj_armed = 0;
            e.wr = 1; e.a = 8'h20; e.d = 8'hD2; e.req = "R12";
            exp_q.push_back(e);
            hd_req = 1;
            req_valid = 1; req_write = 1; req_addr = 8'h20; req_wdata = 8'hD2;
            @(negedge clk);
            hd_req = 0;
            send_req(1, 8'h20, 8'hD2);
            while (exp_q.size() != 0) @(negedge clk);
            repeat (6) @(negedge clk);
            check(hd_cnt == h0 + 1 && hd_cyc < done_cyc, "R12", "helper before client", hd_cyc, done_cyc);
            check(phy_regs[8'h11] == 8'h01, "R11", "falling enable set again", phy_regs[8'h11], 1);
        end

        check(err_hold == 0, "R5", "byte changed before NXT", err_hold, 0);
        check(err_stp == 0, "R6", "stop strobe violations", err_stp, 0);
        check(err_drive == 0, "R8", "link drove bus while PHY owned it", err_drive, 0);
    endtask

    initial begin
        bit timeout;
        timeout = 0;
        fork
            run_tests();
            begin
                repeat (WATCHDOG) @(posedge clk);
                timeout = 1;
            end
        join_any
        if (timeout) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule